// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block moves a small controller core between running, idle and sleep. A one-cycle sleep strobe from the core moves it to idle or to sleep, depending on an idle-enable bit. In idle, the core clock is gated while the selected system oscillator keeps running. In sleep, the system oscillators are stopped and the clock-source status is cleared. Only the low-frequency oscillator (when the watchdog needs it) and the secondary oscillator (when it is told to stay up) keep running.

An interrupt, a reset event or a watchdog time-out ends sleep. The core clock can then be held off until the selected oscillator reports ready. Alternatively, when two-speed start-up or the fail-safe monitor is enabled, the core is clocked at once from the internal oscillator block until that source is ready.

A two-bit regulator mode register chooses how deep the regulator goes during sleep: high power, low power, or main regulator off with an ultra-low-power regulator and an optional forced band gap. Any low-power choice adds a fixed settle delay before the wake hand-off starts.

Top module: `pwr_seq_top`

## Requirements
- R1: In run, a sleep strobe with idle-enable 0 enters sleep at the next clock edge. The core clock enable is then 0, all three source status bits are 0, and the primary and internal high-frequency oscillator enables are 0.
- R2: In run, a sleep strobe with idle-enable 1 enters idle. In idle the core clock enable is 0, the selected oscillator stays enabled and the source status is kept. Any wake event returns the block to run at the next edge, with the core clock enabled.
- R3: In sleep, the low-frequency oscillator enable follows the watchdog-enable input, and the secondary oscillator enable follows the keep-secondary input.
- R4: Only a wake event ends sleep. A sleep strobe arriving while the block is not in run has no effect.
- R5: Clock-select encoding: 00 is primary, 01 is secondary, 10 and 11 are the internal block. Without two-speed start-up or fail-safe, the core clock stays off after wake while the selected oscillator is enabled. At the first edge where that source's ready input is high, the block enters run.
- R6: With two-speed start-up or fail-safe enabled, the core clock is on from the cycle after the wake hand-off. Its source status is the internal block, and the selected oscillator is enabled. When the selected source is ready, status switches to that source.
- R7: Source status bits are bit 0 primary, bit 1 secondary and bit 2 internal, with at most one set. Bit 0 is set only in run or idle with clock-select 00.
- R8: Regulator output encoding is 00 high power, 01 low power and 10 main regulator off. In sleep, mode 00 gives high power. Mode 01 gives low power. Mode 10 gives off, ultra-low-power on and band gap on. Mode 11 gives off, ultra-low-power on and band gap off. Outside sleep the output is high power, ultra-low-power off and band gap on.
- R9: In mode 01, a peripheral high-power request seen at any time during sleep keeps the regulator at high power for the rest of that sleep.
- R10: The mode register resets to 0, takes write data bits 1:0, and reads back with bits 7:2 as 0.
- R11: If the regulator output is not high power in the wake cycle, the core clock is held off for SETTLE_CYC cycles before the hand-off of R5 or R6. With high power there is no delay.
- R12: A reset wake event clears the mode register, taking priority over a write in the same cycle. Interrupt and watchdog wakes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep strobe from the core |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep |
| clk_sel | input | 2 | Selected system clock source |
| wake_irq | input | 1 | Interrupt wake event |
| wake_rst | input | 1 | Reset wake event |
| wake_wdt | input | 1 | Watchdog time-out wake event |
| osc_pri_rdy | input | 1 | Primary oscillator ready |
| osc_sec_rdy | input | 1 | Secondary oscillator ready |
| osc_int_rdy | input | 1 | Internal oscillator block ready |
| two_speed_en | input | 1 | Two-speed start-up enable |
| failsafe_en | input | 1 | Fail-safe clock monitor enable |
| wdt_en | input | 1 | Watchdog enabled, keeps the low-frequency oscillator on |
| sec_keep | input | 1 | Keep the secondary oscillator running |
| hp_req | input | 1 | Peripheral high-power request |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode register write data |
| mode_rdata | output | 8 | Mode register read data |
| core_clk_en | output | 1 | Core clock gate enable |
| src_stat | output | 3 | One-hot clock source status |
| osc_pri_en | output | 1 | Primary oscillator enable |
| osc_sec_en | output | 1 | Secondary oscillator enable |
| osc_int_en | output | 1 | Internal high-frequency oscillator enable |
| osc_lf_en | output | 1 | Low-frequency oscillator enable |
| vreg_mode | output | 2 | Regulator power state |
| ulp_on | output | 1 | Ultra-low-power regulator on |
| bg_on | output | 1 | Band gap reference on |

## Verification
The wake path is tried in four ways: with the selected source held not ready, with a fast start-up enable set, with a low-power regulator setting, and with a high-power request during sleep. Holding ready low separates gating the core from falling back to the internal block. The regulator cases separate a settle delay of exactly SETTLE_CYC cycles from none. Each of the four mode values is decoded in sleep and outside it. Interrupt, watchdog and reset wakes are compared for their effect on the mode register, and a sleep strobe in sleep shows that sleep is left only by a wake event.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_WAIT   = 3'd4,
        ST_FALLBK = 3'd5
    } pwr_state_e;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        VREG_HP  = 2'b00,
        VREG_LP  = 2'b01,
        VREG_OFF = 2'b10
    } vreg_e;

    typedef struct packed {
        vreg_e ldo;
        logic  ulp;
        logic  bg;
    } vreg_ctl_t;

    localparam int SRC_COUNT = 3;

    function automatic clk_src_e sel_decode(input logic [1:0] sel);
        case (sel)
            2'b00:   return SRC_PRI;
            2'b01:   return SRC_SEC;
            default: return SRC_INT;
        endcase
    endfunction

    function automatic logic [SRC_COUNT-1:0] src_onehot(input clk_src_e s);
        logic [SRC_COUNT-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    // Active means some system oscillator is wanted (not sleep, not settle).
    function automatic logic osc_active(input pwr_state_e s);
        return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_WAIT) || (s == ST_FALLBK);
    endfunction

endpackage

// File: rtl/pwr_vreg_ctrl.sv
module pwr_vreg_ctrl
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_sleep,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       clr,
    input  logic       hp_req,
    output logic [1:0] mode_q,
    output vreg_ctl_t  ctl,
    output logic       lp_sleep
);
    logic [1:0] mode_r;
    logic       hp_hold;
    logic       hp_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= 2'b00;
        end else if (clr) begin
            mode_r <= 2'b00;
        end else if (wr_en) begin
            mode_r <= wr_data;
        end
    end

    // Sticky request: once seen during a sleep it holds until sleep ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            hp_hold <= 1'b0;
        end else if (in_sleep) begin
            hp_hold <= hp_hold | hp_req;
        end else begin
            hp_hold <= 1'b0;
        end
    end

    assign hp_any = hp_hold | hp_req;

    always_comb begin
        ctl.ldo = VREG_HP;
        ctl.ulp = 1'b0;
        ctl.bg  = 1'b1;
        if (in_sleep) begin
            case (mode_r)
                2'b00: ctl.ldo = VREG_HP;
                2'b01: ctl.ldo = hp_any ? VREG_HP : VREG_LP;
                2'b10: begin
                    ctl.ldo = VREG_OFF;
                    ctl.ulp = 1'b1;
                end
                default: begin
                    ctl.ldo = VREG_OFF;
                    ctl.ulp = 1'b1;
                    ctl.bg  = 1'b0;
                end
            endcase
        end
    end

    assign lp_sleep = in_sleep && (ctl.ldo != VREG_HP);
    assign mode_q   = mode_r;

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic       wake_any,
    input  logic       fast_start,
    input  logic       sel_rdy,
    input  logic       lp_sleep,
    output pwr_state_e state
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC - 1);

    pwr_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    pwr_state_e handoff;

    assign handoff = fast_start ? ST_FALLBK : ST_WAIT;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_RUN: begin
                if (sleep_req) st_d = idle_en ? ST_IDLE : ST_SLEEP;
            end
            ST_IDLE: begin
                if (wake_any) st_d = ST_RUN;
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    if (lp_sleep) begin
                        st_d  = ST_SETTLE;
                        cnt_d = CNT_LOAD;
                    end else begin
                        st_d = handoff;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) st_d = handoff;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_WAIT, ST_FALLBK: begin
                if (sel_rdy) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pwr_seq_pkg::*;
(
    input  pwr_state_e           state,
    input  logic [1:0]           clk_sel,
    input  logic                 pri_rdy,
    input  logic                 sec_rdy,
    input  logic                 int_rdy,
    input  logic                 wdt_en,
    input  logic                 sec_keep,
    output logic                 sel_rdy,
    output logic                 core_en,
    output logic [SRC_COUNT-1:0] stat,
    output logic                 pri_en,
    output logic                 sec_en,
    output logic                 int_en,
    output logic                 lf_en
);
    clk_src_e sel;
    logic     act;
    logic [SRC_COUNT-1:0] rdy_vec;

    assign sel     = sel_decode(clk_sel);
    assign act     = osc_active(state);
    assign rdy_vec = {int_rdy, sec_rdy, pri_rdy};
    assign sel_rdy = rdy_vec[sel];

    always_comb begin
        core_en = 1'b0;
        stat    = '0;
        case (state)
            ST_RUN: begin
                core_en = 1'b1;
                stat    = src_onehot(sel);
            end
            ST_IDLE:   stat = src_onehot(sel);
            ST_FALLBK: begin
                core_en = 1'b1;
                stat    = src_onehot(SRC_INT);
            end
            default: ;
        endcase
    end

    assign pri_en = act && (sel == SRC_PRI);
    assign sec_en = sec_keep || (act && (sel == SRC_SEC));
    assign int_en = (act && (sel == SRC_INT)) || (state == ST_FALLBK);
    assign lf_en  = wdt_en;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       wake_irq,
    input  logic       wake_rst,
    input  logic       wake_wdt,
    input  logic       osc_pri_rdy,
    input  logic       osc_sec_rdy,
    input  logic       osc_int_rdy,
    input  logic       two_speed_en,
    input  logic       failsafe_en,
    input  logic       wdt_en,
    input  logic       sec_keep,
    input  logic       hp_req,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output logic [7:0] mode_rdata,
    output logic       core_clk_en,
    output logic [2:0] src_stat,
    output logic       osc_pri_en,
    output logic       osc_sec_en,
    output logic       osc_int_en,
    output logic       osc_lf_en,
    output logic [1:0] vreg_mode,
    output logic       ulp_on,
    output logic       bg_on
);
    pwr_state_e state;
    vreg_ctl_t  vctl;
    logic [1:0] mode_q;
    logic       lp_sleep;
    logic       sel_rdy;
    logic       wake_any;
    logic       in_sleep;

    assign wake_any = wake_irq | wake_rst | wake_wdt;
    assign in_sleep = (state == ST_SLEEP);

    pwr_vreg_ctrl u_vreg (
        .clk      (clk),
        .rst      (rst),
        .in_sleep (in_sleep),
        .wr_en    (mode_wr),
        .wr_data  (mode_wdata),
        .clr      (wake_rst),
        .hp_req   (hp_req),
        .mode_q   (mode_q),
        .ctl      (vctl),
        .lp_sleep (lp_sleep)
    );

    pwr_clk_ctrl u_clk (
        .state    (state),
        .clk_sel  (clk_sel),
        .pri_rdy  (osc_pri_rdy),
        .sec_rdy  (osc_sec_rdy),
        .int_rdy  (osc_int_rdy),
        .wdt_en   (wdt_en),
        .sec_keep (sec_keep),
        .sel_rdy  (sel_rdy),
        .core_en  (core_clk_en),
        .stat     (src_stat),
        .pri_en   (osc_pri_en),
        .sec_en   (osc_sec_en),
        .int_en   (osc_int_en),
        .lf_en    (osc_lf_en)
    );

    pwr_state_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .idle_en    (idle_en),
        .wake_any   (wake_any),
        .fast_start (two_speed_en | failsafe_en),
        .sel_rdy    (sel_rdy),
        .lp_sleep   (lp_sleep),
        .state      (state)
    );

    assign mode_rdata = {6'b0, mode_q};
    assign vreg_mode  = vctl.ldo;
    assign ulp_on     = vctl.ulp;
    assign bg_on      = vctl.bg;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input pwr_state_e state,
    input logic       sleep_req,
    input logic       idle_en,
    input logic [1:0] clk_sel,
    input logic       wake_irq,
    input logic       wake_rst,
    input logic       wake_wdt,
    input logic       mode_wr,
    input logic       hp_req,
    input logic       core_clk_en,
    input logic [2:0] src_stat,
    input logic [7:0] mode_rdata,
    input logic [1:0] vreg_mode,
    input logic       ulp_on,
    input logic       bg_on
);
    assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && sleep_req && !idle_en)
            |=> (state == ST_SLEEP && !core_clk_en && src_stat == 3'b000));

    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && sleep_req && idle_en) |=> (state == ST_IDLE && !core_clk_en));

    assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake_irq && !wake_rst && !wake_wdt) |=> (state == ST_SLEEP));

    assert_wait_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (!core_clk_en && src_stat == 3'b000));

    assert_fallback_clk_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FALLBK) |-> (core_clk_en && src_stat == 3'b100));

    assert_src_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_stat));

    assert_pri_flag_R7: assert property (@(posedge clk) disable iff (rst)
        src_stat[0] |-> ((state == ST_RUN || state == ST_IDLE) && clk_sel == 2'b00));

    assert_deep_decode_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && mode_rdata[1:0] == 2'b11)
            |-> (vreg_mode == 2'b10 && ulp_on && !bg_on));

    assert_hp_override_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && mode_rdata[1:0] == 2'b01 && hp_req) |-> (vreg_mode == 2'b00));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        mode_rdata[7:2] == 6'b0);

    assert_settle_gated_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |-> (!core_clk_en && vreg_mode == 2'b00));

    assert_rst_clears_R12: assert property (@(posedge clk) disable iff (rst)
        wake_rst |=> (mode_rdata == 8'h00));

    assert_mode_kept_R12: assert property (@(posedge clk) disable iff (rst)
        ((wake_irq || wake_wdt) && !wake_rst && !mode_wr) |=> (mode_rdata == $past(mode_rdata)));

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .sleep_req   (sleep_req),
    .idle_en     (idle_en),
    .clk_sel     (clk_sel),
    .wake_irq    (wake_irq),
    .wake_rst    (wake_rst),
    .wake_wdt    (wake_wdt),
    .mode_wr     (mode_wr),
    .hp_req      (hp_req),
    .core_clk_en (core_clk_en),
    .src_stat    (src_stat),
    .mode_rdata  (mode_rdata),
    .vreg_mode   (vreg_mode),
    .ulp_on      (ulp_on),
    .bg_on       (bg_on)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;
    localparam int SETTLE = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 0, idle_en = 0, wake_irq = 0, wake_rst = 0, wake_wdt = 0;
    logic [1:0] clk_sel = 2'b00;
    logic osc_pri_rdy = 1, osc_sec_rdy = 1, osc_int_rdy = 1;
    logic two_speed_en = 0, failsafe_en = 0, wdt_en = 0, sec_keep = 0, hp_req = 0;
    logic mode_wr = 0;
    logic [1:0] mode_wdata = 2'b00;
    logic [7:0] mode_rdata;
    logic core_clk_en, osc_pri_en, osc_sec_en, osc_int_en, osc_lf_en, ulp_on, bg_on;
    logic [2:0] src_stat;
    logic [1:0] vreg_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_seq_top #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .idle_en(idle_en), .clk_sel(clk_sel),
        .wake_irq(wake_irq), .wake_rst(wake_rst), .wake_wdt(wake_wdt),
        .osc_pri_rdy(osc_pri_rdy), .osc_sec_rdy(osc_sec_rdy), .osc_int_rdy(osc_int_rdy),
        .two_speed_en(two_speed_en), .failsafe_en(failsafe_en), .wdt_en(wdt_en),
        .sec_keep(sec_keep), .hp_req(hp_req), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .core_clk_en(core_clk_en), .src_stat(src_stat),
        .osc_pri_en(osc_pri_en), .osc_sec_en(osc_sec_en), .osc_int_en(osc_int_en),
        .osc_lf_en(osc_lf_en), .vreg_mode(vreg_mode), .ulp_on(ulp_on), .bg_on(bg_on)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] v);
        mode_wr = 1; mode_wdata = v; tick(); mode_wr = 0;
    endtask

    task automatic go_sleep();
        sleep_req = 1; tick(); sleep_req = 0;
    endtask

    task automatic wake(input int kind);
        case (kind)
            0: wake_irq = 1;
            1: wake_wdt = 1;
            default: wake_rst = 1;
        endcase
        tick();
        wake_irq = 0; wake_wdt = 0; wake_rst = 0;
    endtask

    task automatic t_reset();
        chk("R10", "mode after reset", mode_rdata, 8'h00);
        chk("R7", "src after reset", src_stat, 3'b001);
        chk("R8", "regulator in run", {vreg_mode, ulp_on, bg_on}, 4'b0001);
        chk("R2", "core clock in run", core_clk_en, 1);
    endtask

    task automatic t_register();
        write_mode(2'b11);
        chk("R10", "readback 11", mode_rdata, 8'h03);
        write_mode(2'b10);
        chk("R10", "readback 10", mode_rdata, 8'h02);
        write_mode(2'b00);
    endtask

    task automatic t_idle();
        idle_en = 1;
        go_sleep();
        chk("R2", "idle core gated", core_clk_en, 0);
        chk("R2", "idle osc kept", osc_pri_en, 1);
        chk("R2", "idle status kept", src_stat, 3'b001);
        tick(); tick();
        chk("R2", "idle holds", core_clk_en, 0);
        wake(0);
        chk("R2", "idle wake to run", core_clk_en, 1);
        idle_en = 0;
    endtask

    task automatic t_sleep_wait();
        go_sleep();
        chk("R1", "sleep core gated", core_clk_en, 0);
        chk("R1", "sleep status clear", src_stat, 3'b000);
        chk("R1", "sleep pri osc off", osc_pri_en, 0);
        chk("R1", "sleep int osc off", osc_int_en, 0);
        osc_pri_rdy = 0;
        go_sleep();
        tick();
        chk("R4", "strobe in sleep ignored", {core_clk_en, osc_pri_en}, 2'b00);
        wake(0);
        chk("R5", "wait core gated", core_clk_en, 0);
        chk("R5", "wait osc enabled", osc_pri_en, 1);
        tick(); tick();
        chk("R5", "still waiting", {core_clk_en, src_stat}, 4'b0000);
        osc_pri_rdy = 1;
        tick();
        chk("R5", "run after ready", core_clk_en, 1);
        chk("R7", "primary flag set", src_stat, 3'b001);
    endtask

    task automatic t_osc_keep();
        wdt_en = 1; sec_keep = 1;
        go_sleep();
        chk("R3", "lf kept", osc_lf_en, 1);
        chk("R3", "sec kept", osc_sec_en, 1);
        chk("R3", "pri off", osc_pri_en, 0);
        wake(1);
        chk("R5", "watchdog wake gated", core_clk_en, 0);
        tick();
        chk("R5", "watchdog wake run", core_clk_en, 1);
        wdt_en = 0; sec_keep = 0;
        go_sleep();
        chk("R3", "lf off", osc_lf_en, 0);
        chk("R3", "sec off", osc_sec_en, 0);
        wake(0); tick();
    endtask

    task automatic t_fallback();
        two_speed_en = 1;
        go_sleep();
        osc_pri_rdy = 0;
        wake(0);
        chk("R6", "fallback core on", core_clk_en, 1);
        chk("R6", "fallback internal", src_stat, 3'b100);
        chk("R6", "fallback pri osc on", osc_pri_en, 1);
        tick();
        chk("R7", "no primary flag yet", src_stat[0], 0);
        osc_pri_rdy = 1;
        tick();
        chk("R6", "switch to primary", src_stat, 3'b001);
        chk("R6", "internal released", osc_int_en, 0);
        two_speed_en = 0; failsafe_en = 1; clk_sel = 2'b01;
        tick();
        chk("R7", "secondary status", src_stat, 3'b010);
        go_sleep();
        osc_sec_rdy = 0;
        wake(0);
        chk("R6", "failsafe fallback", src_stat, 3'b100);
        osc_sec_rdy = 1;
        tick();
        chk("R6", "switch to secondary", src_stat, 3'b010);
        clk_sel = 2'b00; failsafe_en = 0;
        tick();
    endtask

    task automatic t_regulator();
        go_sleep();
        chk("R8", "mode 00 sleep", {vreg_mode, ulp_on, bg_on}, 4'b0001);
        wake(0);
        chk("R11", "no settle at high power", core_clk_en, 0);
        tick();
        chk("R11", "run right after wait", core_clk_en, 1);
        write_mode(2'b10);
        go_sleep();
        chk("R8", "mode 10 sleep", {vreg_mode, ulp_on, bg_on}, 4'b1011);
        wake(1);
        chk("R12", "watchdog keeps mode", mode_rdata, 8'h02);
        repeat (SETTLE + 2) tick();
        write_mode(2'b01);
        go_sleep();
        chk("R8", "mode 01 sleep", {vreg_mode, ulp_on, bg_on}, 4'b0101);
        wake(0);
        chk("R12", "interrupt keeps mode", mode_rdata, 8'h01);
        repeat (SETTLE + 2) tick();
    endtask

    task automatic t_settle();
        two_speed_en = 1;
        write_mode(2'b11);
        go_sleep();
        chk("R8", "mode 11 sleep", {vreg_mode, ulp_on, bg_on}, 4'b1010);
        wake(0);
        for (int i = 1; i < SETTLE; i++) tick();
        chk("R11", "gated through settle", core_clk_en, 0);
        chk("R11", "regulator high in settle", vreg_mode, 2'b00);
        tick();
        chk("R11", "core on after settle", core_clk_en, 1);
        two_speed_en = 0;
    endtask

    task automatic t_hp_override();
        two_speed_en = 1;
        write_mode(2'b01);
        go_sleep();
        hp_req = 1; tick(); hp_req = 0;
        chk("R9", "request held high power", vreg_mode, 2'b00);
        tick();
        chk("R9", "request sticky", vreg_mode, 2'b00);
        wake(0);
        chk("R11", "no settle after override", core_clk_en, 1);
        two_speed_en = 0;
    endtask

    task automatic t_reset_wake();
        write_mode(2'b10);
        go_sleep();
        wake(2);
        chk("R12", "reset wake clears mode", mode_rdata, 8'h00);
        repeat (SETTLE + 2) tick();
        chk("R12", "reset wake reaches run", core_clk_en, 1);
        wake_rst = 1; mode_wr = 1; mode_wdata = 2'b11;
        tick();
        wake_rst = 0; mode_wr = 0;
        chk("R12", "clear beats write", mode_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_register();
        t_idle();
        t_sleep_wait();
        t_osc_keep();
        t_fallback();
        t_regulator();
        t_settle();
        t_hp_override();
        t_reset_wake();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule